// File: doc/BRIEF.md
# Dual-Mode Programmable Delay Register

This block models, one system clock at a time, a delay element with an 8-bit setting. A logic input `sig_in` comes back out on `sig_out` after a fixed base latency plus one system-clock step for each count of the active setting. The steps are held in a shift line of samples, and a tap multiplexer picks the one to output.

The setting has two load paths, chosen by `par_mode`. In parallel mode an 8-bit bus is captured under control of `load_en`. While `load_en` is high the setting follows the bus, and while it is low the setting is held. In serial mode, bits on `sdi` shift MSB first into a shadow register on each rising edge of `sclk` while `load_en` is high. The old contents leave on `sdo`, so parts can be chained. Feeding `sdo` back into `sdi` reads the setting without destroying it. The shadow word becomes the active setting only when `load_en` falls.

`load_en` and `sclk` are asynchronous to `clk`. They pass through a synchroniser, and their edges are detected after it. The sample stream is a plain per-cycle signal with no handshake: one sample enters and one leaves every clock, so there is no back-pressure.

Top module: `prog_delay_line`

## Requirements
- R1: After reset the active setting and the shadow register are 0, `sdo` is 0 and `sig_out` is 0 until input samples reach the active tap.
- R2: `sig_out` equals the value `sig_in` had BASE_CYCLES plus the active setting clock cycles earlier (4 + setting with defaults).
- R3: With `par_mode`=1 and synchronised `load_en`=1, the active setting follows `set_bus`.
- R4: With `par_mode`=1 and `load_en`=0, changes on `set_bus` leave the active setting unchanged.
- R5: With `par_mode`=0 and `load_en`=1, each rising `sclk` edge shifts `sdi` into bit 0 of the shadow register, so words enter MSB first. `sclk` edges while `load_en`=0 do not shift.
- R6: While `par_mode`=0 and `load_en`=1, the delay keeps using the last activated setting.
- R7: A falling `load_en` in serial mode copies the shadow register into the active setting.
- R8: While `load_en`=1, `sdo` shows shadow bit 7, so the first bit is present before any `sclk` edge, and each rising `sclk` edge presents the next lower bit. `sdo` is 0 while `load_en`=0.
- R9: Eight shifts with `sdo` looped back to `sdi` restore the shadow word. Committing it then leaves the delay unchanged with no disturbance of `sig_out`.
- R10: In serial mode `set_bus` has no effect on the setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_mode | input | 1 | 1 selects parallel load, 0 selects serial load |
| load_en | input | 1 | Load enable / latch control (asynchronous) |
| set_bus | input | 8 | Parallel setting value |
| sclk | input | 1 | Serial shift clock (asynchronous) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (shadow bit 7) |
| sig_in | input | 1 | Logic input to delay |
| sig_out | output | 1 | Delayed logic output |

## Verification
A pseudo-random bit stream runs through the delay the whole time. It is checked against its own recorded history at the delay implied by each setting: zero, small, near full scale and loaded serially. Unlike a constant or a clock pattern, this separates a tap that is off by one step from a correct one. Bus changes with the latch closed, bus changes in serial mode, and `sclk` edges with enable low show that ignored inputs really are ignored. The shift and read-back sequence compares `sdo` bit by bit with the previous word and watches the stream through the commit, which tells a clean restore from a glitch.

// File: rtl/pdl_pkg.sv
package pdl_pkg;
  localparam int SET_W_DEF = 8;
  localparam int BASE_DEF  = 4;
  localparam int SYNC_DEF  = 2;
  // index of each asynchronous control in the synchroniser bank
  localparam int IDX_EN   = 0;
  localparam int IDX_SCLK = 1;
  localparam int N_ASYNC  = 2;
endpackage

// File: rtl/pdl_sync.sv
module pdl_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out,
  output logic [N-1:0] sync_prev
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain        <= '0;
        sync_prev[b] <= 1'b0;
      end else begin
        chain        <= {chain[STAGES-2:0], async_in[b]};
        sync_prev[b] <= chain[STAGES-1];
      end
    end
    assign sync_out[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/pdl_setting.sv
module pdl_setting #(
  parameter int SET_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             par_mode,
  input  logic             en_s,
  input  logic             en_fall,
  input  logic             sclk_rise,
  input  logic [SET_W-1:0] bus,
  input  logic             sdi,
  output logic [SET_W-1:0] active,
  output logic             sdo
);
  logic [SET_W-1:0] shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= '0;
      shadow <= '0;
    end else if (par_mode) begin
      if (en_s) active <= bus;
    end else begin
      if (en_s && sclk_rise) shadow <= {shadow[SET_W-2:0], sdi};
      if (en_fall)           active <= shadow;
    end
  end

  assign sdo = en_s & shadow[SET_W-1];

  // R6
  hold_during_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_mode && en_s) |=> $stable(active));
  // R7
  commit_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_mode && en_fall) |=> (active == $past(shadow)));
  // R3
  bus_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_mode && en_s) |=> (active == $past(bus)));
  // R5
  shift_msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_mode && en_s && sclk_rise) |=> (shadow[SET_W-1:1] == $past(shadow[SET_W-2:0])));
  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_mode && !en_s) |=> $stable(active));
endmodule

// File: rtl/pdl_tapline.sv
module pdl_tapline #(
  parameter int SET_W = 8,
  parameter int BASE  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [SET_W-1:0] setting,
  output logic             dout
);
  localparam int LEN   = BASE + (1 << SET_W) - 1;
  localparam int SEL_W = $clog2(LEN);

  logic [LEN-1:0]   hist;
  logic [SEL_W-1:0] sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[LEN-2:0], din};
  end

  assign sel  = SEL_W'(BASE - 1) + SEL_W'(setting);
  assign dout = hist[sel];

  // R2
  always_comb tap_in_range_chk: assert (int'(sel) < LEN);
endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line #(
  parameter int SET_W       = pdl_pkg::SET_W_DEF,
  parameter int BASE_CYCLES = pdl_pkg::BASE_DEF,
  parameter int SYNC_STAGES = pdl_pkg::SYNC_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             par_mode,
  input  logic             load_en,
  input  logic [SET_W-1:0] set_bus,
  input  logic             sclk,
  input  logic             sdi,
  output logic             sdo,
  input  logic             sig_in,
  output logic             sig_out
);
  import pdl_pkg::*;

  logic [N_ASYNC-1:0] raw, cur, prev;
  logic [SET_W-1:0]   active;
  logic               en_fall, sclk_rise;

  assign raw[IDX_EN]   = load_en;
  assign raw[IDX_SCLK] = sclk;

  pdl_sync #(.N(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(raw), .sync_out(cur), .sync_prev(prev));

  assign en_fall   = prev[IDX_EN] & ~cur[IDX_EN];
  assign sclk_rise = cur[IDX_SCLK] & ~prev[IDX_SCLK];

  pdl_setting #(.SET_W(SET_W)) u_setting (
    .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .en_s(cur[IDX_EN]),
    .en_fall(en_fall), .sclk_rise(sclk_rise), .bus(set_bus), .sdi(sdi),
    .active(active), .sdo(sdo));

  pdl_tapline #(.SET_W(SET_W), .BASE(BASE_CYCLES)) u_tap (
    .clk(clk), .rst_n(rst_n), .din(sig_in), .setting(active), .dout(sig_out));

  // R8
  sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cur[IDX_EN] |-> !sdo);
endmodule

// File: tb/test_prog_delay_line.sv
module test_prog_delay_line;
  localparam int BASE = 4;

  logic clk = 0, rst_n = 0;
  logic par_mode = 0, load_en = 0, sclk = 0, sdi = 0, sig_in = 0;
  logic [7:0] set_bus = 0;
  logic sdo, sig_out;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit drive_on = 0, chk_on = 0;
  int chk_d = BASE;
  string chk_tag = "R2";
  bit exp_q[$];
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  prog_delay_line i_prog_delay_line (
    .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .load_en(load_en),
    .set_bus(set_bus), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .sig_in(sig_in), .sig_out(sig_out));

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // driver pushes each sample; monitor compares the output first
  always @(negedge clk) begin
    cyc++;
    if (chk_on) begin
      bit e;
      e = (exp_q.size() >= chk_d) ? exp_q[exp_q.size() - chk_d] : 1'b0;
      check(sig_out == e, chk_tag, sig_out, e);
    end
    if (drive_on) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sig_in = lfsr[0];
      exp_q.push_back(lfsr[0]);
      if (exp_q.size() > 300) void'(exp_q.pop_front());
    end
  end

  always @(negedge clk) if (cyc > 150000) begin
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    finish_run();
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stream(int d, string tag, int n);
    chk_d = d; chk_tag = tag; chk_on = 1;
    wait_n(n);
  endtask

  // shift one word; verifies sdo against old word; loop feeds sdo back
  task automatic ser_word(logic [7:0] w, logic [7:0] old, bit loop);
    for (int i = 0; i < 8; i++) begin
      check(sdo == old[7-i], "R8", sdo, old[7-i]);
      sdi = loop ? sdo : w[7-i];
      wait_n(3);
      sclk = 1;
      wait_n(4);
      sclk = 0;
      wait_n(3);
    end
  endtask

  initial begin
    wait_n(3);
    rst_n = 1;
    @(negedge clk);
    check(sdo == 0, "R1", sdo, 0);
    check(sig_out == 0, "R1", sig_out, 0);
    drive_on = 1;
    stream(BASE, "R1", 40);
    stream(BASE, "R2", 260);

    // parallel, transparent
    chk_on = 0; par_mode = 1; set_bus = 10; load_en = 1; wait_n(6);
    stream(BASE + 10, "R3", 260);
    chk_on = 0; set_bus = 200; wait_n(6);
    stream(BASE + 200, "R2", 260);
    // latch closed: bus ignored
    chk_on = 0; load_en = 0; wait_n(6);
    set_bus = 33;
    stream(BASE + 200, "R4", 260);
    // serial mode: bus ignored
    par_mode = 0; set_bus = 77;
    stream(BASE + 200, "R10", 100);
    // serial write 0x5A, delay unchanged while enabled
    load_en = 1; wait_n(6);
    chk_tag = "R6";
    ser_word(8'h5A, 8'h00, 0);
    chk_on = 0; load_en = 0; wait_n(6);
    check(sdo == 0, "R8", sdo, 0);
    stream(BASE + 8'h5A, "R7", 260);
    // sclk edges with enable low must not shift
    sdi = 1;
    repeat (8) begin sclk = 1; wait_n(4); sclk = 0; wait_n(4); end
    // read back with loop, stream checked across commit
    load_en = 1; wait_n(6);
    chk_tag = "R9";
    ser_word(8'h00, 8'h5A, 1);
    load_en = 0;
    stream(BASE + 8'h5A, "R9", 260);
    // re-read: word restored and still untouched by the low-enable clocks (R5)
    chk_on = 0; load_en = 1; wait_n(6);
    ser_word(8'h03, 8'h5A, 0);
    load_en = 0; wait_n(6);
    stream(BASE + 3, "R5", 260);
    chk_on = 0;
    finish_run();
  end
endmodule